// File: doc/BRIEF.md
# Whole-Chip Erase Command Decoder

This block is the device-side command logic of a serial flash for a whole-chip erase. It watches a chip-select / serial-clock / data interface, oversampled in the device clock domain. It collects an 8-bit instruction, either one bit per clock on a single line (SPI) or one nibble per clock on four lines (QPI). Both serial clock idle levels are accepted: low (mode 0) and high (mode 3). The block holds a two-bit status word, a busy flag and a write-enable flag. It serves a status-read command at all times and lets a write-enable command set the enable flag.

An erase command is accepted only when all of the following hold:
- chip select rises exactly when the eighth instruction bit has been taken in;
- the write-enable flag is set;
- the protection inputs leave the whole array writable;
- no earlier erase is still running.

An accepted erase starts a self-timed cycle measured by a clock-cycle counter. When the count ends, the block raises a one-cycle array-clear strobe that tells the array to return every byte to FFh, and it drops both status flags.

Top module: `chip_erase_ctrl`

## Requirements
- R1: Opcodes C7h and 60h each start an erase when the other conditions hold; every started erase produces exactly one `array_clear` pulse.
- R2: An erase opcode sent while the write-enable flag is 0 starts nothing.
- R3: A frame counts only if chip select rises after exactly 8 instruction bits: 8 clock rises in SPI, 2 in QPI. A frame with fewer or more rises is discarded and leaves the status unchanged.
- R4: The erase is refused when `lock_any` is 1. With `prot_cmp`=0 it is refused when `prot_bp` is not 000. With `prot_cmp`=1 it is refused unless `prot_bp` is 111.
- R5: `array_clear` is high for one clock, ERASE_CYCLES+3 device clocks after the first clock edge that sees `spi_csn` high at the end of the erase frame. Busy reads 1 from that chip-select rise until the strobe.
- R6: When the strobe fires, busy and the write-enable flag both return to 0.
- R7: Opcode 05h returns the status byte MSB first: bit 0 is busy, bit 1 is write-enable, bits 7..2 are 0. It works during an erase. While chip select stays low the byte repeats, reloaded live each time.
- R8: Opcode 06h sets the write-enable flag when the block is not busy.
- R9: While busy, every command other than 05h is ignored; in particular, a second erase does not restart or extend the cycle.
- R10: Serial clock idle low (mode 0) and idle high (mode 3) both work. Inputs are taken on rising edges and status bits change on falling edges.
- R11: With `qpi_en`=0, instructions enter on lane 0 and status leaves on lane 1, with `spi_io_oe`=0010. With `qpi_en`=1, both use lanes 3..0, high nibble first, with `spi_io_oe`=1111.
- R12: `spi_io_oe` is 0 while chip select is high and while instruction bits are being shifted in.
- R13: After reset, `spi_io_oe` and `array_clear` are 0 and the status reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_io_in | input | 4 | Data lanes as seen at the pins |
| spi_io_out | output | 4 | Data lanes driven by the block |
| spi_io_oe | output | 4 | Per-lane output enable |
| qpi_en | input | 1 | 1 selects four-lane transfers |
| prot_cmp | input | 1 | Complement flag of the protection field |
| prot_bp | input | 3 | Block protection field |
| lock_any | input | 1 | 1 when any individual block lock is set |
| array_clear | output | 1 | One-cycle strobe: set the whole array to FFh |

## Verification
Each serial pin passes a two-stage synchronizer and an edge register, so a chip-select or clock edge takes effect three device clocks after it is driven. The bench holds each serial clock half period for six device clocks and samples status lanes at the end of the low half. A status bit therefore has settled well before it is read. Status bytes are queued as expectations before the frame that reads them and compared as each byte is assembled. The strobe monitor measures the distance from the chip-select rise to the strobe against ERASE_CYCLES+3 within a two-cycle tolerance, and flags any strobe that no accepted erase predicts. Each refused or ignored command is followed by a status read, so its lack of effect on the flags is seen at the pins.

// File: rtl/ce_pkg.sv
package ce_pkg;
  localparam int OPC_W  = 8;
  localparam int LANE_W = 4;
  localparam int CNT_W  = 4;

  localparam logic [OPC_W-1:0] OPC_ERASE_PRI = 8'hC7;
  localparam logic [OPC_W-1:0] OPC_ERASE_SEC = 8'h60;
  localparam logic [OPC_W-1:0] OPC_WR_EN     = 8'h06;
  localparam logic [OPC_W-1:0] OPC_RD_STAT   = 8'h05;

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OPC_W);
  localparam logic [CNT_W-1:0] CNT_OVER = '1;

  typedef struct packed {
    logic wel;
    logic busy;
  } stat_t;

  function automatic logic [OPC_W-1:0] stat_byte(stat_t s);
    return {{(OPC_W-2){1'b0}}, s.wel, s.busy};
  endfunction

  function automatic logic region_locked(logic cmp, logic [2:0] bp, logic lock);
    return lock | (cmp ? (bp != 3'b111) : (bp != 3'b000));
  endfunction
endpackage

// File: rtl/ce_sync.sv
module ce_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/ce_framer.sv
module ce_framer
  import ce_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_s,
  input  logic              sck_s,
  input  logic [LANE_W-1:0] io_s,
  input  logic              quad,
  input  logic [OPC_W-1:0]  stat_in,
  output logic              cs_act,
  output logic              cs_rise,
  output logic              frame_exact,
  output logic              instr_phase,
  output logic [OPC_W-1:0]  opcode,
  output logic [LANE_W-1:0] io_out,
  output logic [LANE_W-1:0] io_oe
);
  logic              csn_q, sck_q;
  logic              cs_fall, sck_rise, sck_fall;
  logic [CNT_W-1:0]  cnt_q, cnt_n, step;
  logic [OPC_W-1:0]  op_q, op_n, sh_q, sh_n;
  logic [CNT_W-1:0]  left_q, left_n;
  logic              rd_q, rd_n, oe_q, oe_n;

  assign cs_act   = ~csn_s;
  assign cs_fall  = csn_q & ~csn_s;
  assign cs_rise  = ~csn_q & csn_s;
  assign sck_rise = cs_act & ~sck_q & sck_s;
  assign sck_fall = cs_act & sck_q & ~sck_s;
  assign step     = quad ? CNT_W'(LANE_W) : CNT_W'(1);

  always_comb begin
    cnt_n  = cnt_q;
    op_n   = op_q;
    rd_n   = rd_q;
    left_n = left_q;
    sh_n   = sh_q;
    oe_n   = oe_q;
    if (cs_fall) begin
      cnt_n  = '0;
      op_n   = '0;
      rd_n   = 1'b0;
      oe_n   = 1'b0;
      left_n = '0;
    end else if (cs_rise) begin
      rd_n   = 1'b0;
      oe_n   = 1'b0;
      left_n = '0;
    end else if (sck_rise) begin
      if (cnt_q < CNT_FULL) begin
        op_n  = quad ? {op_q[OPC_W-LANE_W-1:0], io_s} : {op_q[OPC_W-2:0], io_s[0]};
        cnt_n = cnt_q + step;
        if (cnt_n == CNT_FULL && op_n == OPC_RD_STAT) rd_n = 1'b1;
      end else begin
        cnt_n = CNT_OVER;
      end
    end else if (sck_fall && rd_q) begin
      oe_n = 1'b1;
      if (left_q <= step) begin
        sh_n   = stat_in;
        left_n = CNT_FULL;
      end else begin
        sh_n   = quad ? (sh_q << LANE_W) : (sh_q << 1);
        left_n = left_q - step;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_q  <= 1'b1;
      sck_q  <= 1'b0;
      cnt_q  <= '0;
      op_q   <= '0;
      rd_q   <= 1'b0;
      left_q <= '0;
      sh_q   <= '0;
      oe_q   <= 1'b0;
    end else begin
      csn_q  <= csn_s;
      sck_q  <= sck_s;
      cnt_q  <= cnt_n;
      op_q   <= op_n;
      rd_q   <= rd_n;
      left_q <= left_n;
      sh_q   <= sh_n;
      oe_q   <= oe_n;
    end
  end

  assign frame_exact = (cnt_q == CNT_FULL);
  assign instr_phase = cs_act & (cnt_q < CNT_FULL);
  assign opcode      = op_q;

  // Lane mapping: quad uses all lanes from the top nibble, single uses lane 1
  for (genvar l = 0; l < LANE_W; l++) begin : g_lane
    if (l == 1) begin : g_serial
      assign io_out[l] = quad ? sh_q[OPC_W-LANE_W+l] : sh_q[OPC_W-1];
      assign io_oe[l]  = oe_q;
    end else begin : g_quad_only
      assign io_out[l] = quad ? sh_q[OPC_W-LANE_W+l] : 1'b0;
      assign io_oe[l]  = oe_q & quad;
    end
  end
endmodule

// File: rtl/ce_erase_timer.sv
module ce_erase_timer #(
  parameter int unsigned CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);

  logic          run_q, run_n, done_q, done_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    run_n  = run_q;
    cnt_n  = cnt_q;
    done_n = 1'b0;
    if (start) begin
      run_n = 1'b1;
      cnt_n = CW'(CYCLES - 1);
    end else if (run_q) begin
      if (cnt_q == '0) begin
        run_n  = 1'b0;
        done_n = 1'b1;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_n;
      cnt_q  <= cnt_n;
      done_q <= done_n;
    end
  end

  assign done = done_q;
endmodule

// File: rtl/chip_erase_ctrl.sv
module chip_erase_ctrl
  import ce_pkg::*;
#(
  parameter int unsigned ERASE_CYCLES = 1_000_000,
  parameter int          SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_csn,
  input  logic              spi_sck,
  input  logic [LANE_W-1:0] spi_io_in,
  output logic [LANE_W-1:0] spi_io_out,
  output logic [LANE_W-1:0] spi_io_oe,
  input  logic              qpi_en,
  input  logic              prot_cmp,
  input  logic [2:0]        prot_bp,
  input  logic              lock_any,
  output logic              array_clear
);
  logic              csn_s, sck_s;
  logic [LANE_W-1:0] io_s;
  logic              cs_act, cs_rise, frame_exact, instr_phase;
  logic [OPC_W-1:0]  opcode;
  logic              busy_q, busy_n, wel_q, wel_n, start, tmr_done;
  stat_t             stat;

  ce_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_cs (
    .clk(clk), .rst_n(rst_n), .d(spi_csn), .q(csn_s));
  ce_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_sck (
    .clk(clk), .rst_n(rst_n), .d(spi_sck), .q(sck_s));
  ce_sync #(.W(LANE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_sync_io (
    .clk(clk), .rst_n(rst_n), .d(spi_io_in), .q(io_s));

  assign stat.busy = busy_q;
  assign stat.wel  = wel_q;

  ce_framer i_framer (
    .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .sck_s(sck_s), .io_s(io_s),
    .quad(qpi_en), .stat_in(stat_byte(stat)), .cs_act(cs_act),
    .cs_rise(cs_rise), .frame_exact(frame_exact), .instr_phase(instr_phase),
    .opcode(opcode), .io_out(spi_io_out), .io_oe(spi_io_oe));

  ce_erase_timer #(.CYCLES(ERASE_CYCLES)) i_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .done(tmr_done));

  always_comb begin
    busy_n = busy_q;
    wel_n  = wel_q;
    start  = 1'b0;
    if (tmr_done) begin
      busy_n = 1'b0;
      wel_n  = 1'b0;
    end else if (cs_rise && frame_exact && !busy_q) begin
      unique case (opcode)
        OPC_ERASE_PRI, OPC_ERASE_SEC: begin
          if (wel_q && !region_locked(prot_cmp, prot_bp, lock_any)) begin
            start  = 1'b1;
            busy_n = 1'b1;
          end
        end
        OPC_WR_EN: wel_n = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wel_q  <= 1'b0;
    end else begin
      busy_q <= busy_n;
      wel_q  <= wel_n;
    end
  end

  assign array_clear = tmr_done;
endmodule

// File: rtl/ce_checker.sv
module ce_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_act,
  input logic       instr_phase,
  input logic [3:0] io_oe,
  input logic       array_clear,
  input logic       busy,
  input logic       wel,
  input logic       prot_cmp,
  input logic [2:0] prot_bp,
  input logic       lock_any
);
  a_r12_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (io_oe == 4'h0));

  a_r12_quiet_instruction: assert property (@(posedge clk) disable iff (!rst_n)
    instr_phase |-> (io_oe == 4'h0));

  a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    array_clear |=> !array_clear);

  a_r5_strobe_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    array_clear |-> busy);

  a_r6_flags_drop: assert property (@(posedge clk) disable iff (!rst_n)
    array_clear |=> (!busy && !wel));

  a_r6_busy_ends_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(array_clear));

  a_r2_start_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));

  a_r4_start_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!lock_any && (prot_cmp ? (prot_bp == 3'b111) : (prot_bp == 3'b000))));

  a_r11_lane_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'h0) || (io_oe == 4'h2) || (io_oe == 4'hF));
endmodule

bind chip_erase_ctrl ce_checker i_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .instr_phase(instr_phase),
  .io_oe(spi_io_oe), .array_clear(array_clear), .busy(busy_q), .wel(wel_q),
  .prot_cmp(prot_cmp), .prot_bp(prot_bp), .lock_any(lock_any));

// File: tb/test_chip_erase_ctrl.sv
module test_chip_erase_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TCE        = 2000;
  localparam int HALF       = 6;

  logic       clk = 1'b0;
  logic       rst_n, csn, sck, qpi, cmp, lock;
  logic [2:0] bp;
  logic [3:0] io_in, io_out, io_oe;
  logic       clr;

  chip_erase_ctrl #(.ERASE_CYCLES(TCE)) i_chip_erase_ctrl (
    .clk(clk), .rst_n(rst_n), .spi_csn(csn), .spi_sck(sck), .spi_io_in(io_in),
    .spi_io_out(io_out), .spi_io_oe(io_oe), .qpi_en(qpi), .prot_cmp(cmp),
    .prot_bp(bp), .lock_any(lock), .array_clear(clr));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0, cs_cyc = 0, erase_cs = 0, clr_cnt = 0;
  bit lat_expect = 0, clr_prev = 0, finished = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor: pair captured status bytes with queued expectations
  always @(negedge clk) begin
    if (got_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] g, e;
      string t;
      g = got_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(g === e, t, {24'h0, g}, {24'h0, e});
    end
  end

  // Strobe monitor: R1 every strobe predicted, R5 latency and width
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (clr === 1'b1) begin
        int lat;
        lat = cyc - erase_cs;
        clr_cnt++;
        chk(lat_expect, "R1 unpredicted array_clear", 32'h1, 32'h0);
        chk(lat >= TCE + 1 && lat <= TCE + 5, "R5 strobe latency", lat, TCE + 3);
        chk(!clr_prev, "R5 strobe width", 32'h2, 32'h1);
        lat_expect = 0;
      end
      clr_prev = (clr === 1'b1);
    end
  end

  task automatic xfer(input logic [7:0] op, input int units, input int rd_units, input bit m3);
    int step, nb;
    logic [7:0] acc;
    bit oe_bad;
    step = qpi ? 4 : 1;
    nb = 0; acc = '0; oe_bad = 0;
    sck = m3; tick(HALF);
    csn = 1'b0; tick(HALF);
    for (int u = 0; u < units; u++) begin
      sck = 1'b0;
      if (qpi) io_in = (u == 0) ? op[7:4] : (u == 1) ? op[3:0] : 4'h0;
      else     io_in = (u < 8) ? {3'b000, op[3'(7 - u)]} : 4'h0;
      tick(HALF);
      if (io_oe !== 4'h0) oe_bad = 1;
      sck = 1'b1; tick(HALF);
    end
    chk(!oe_bad, "R12 lanes driven during instruction", {31'h0, oe_bad}, 32'h0);
    for (int r = 0; r < rd_units; r++) begin
      sck = 1'b0; tick(HALF);
      chk(io_oe === (qpi ? 4'hF : 4'h2), "R11 lane enables on read", {28'h0, io_oe}, qpi ? 32'hF : 32'h2);
      acc = qpi ? {acc[3:0], io_out} : {acc[6:0], io_out[1]};
      nb += step;
      if (nb >= 8) begin
        got_q.push_back(acc);
        nb = 0;
      end
      sck = 1'b1; tick(HALF);
    end
    if (!m3) begin
      sck = 1'b0; tick(HALF);
    end
    csn = 1'b1;
    cs_cyc = cyc;
    tick(HALF);
    chk(io_oe === 4'h0, "R12 lanes driven while deselected", {28'h0, io_oe}, 32'h0);
    tick(HALF);
  endtask

  task automatic cmd(input logic [7:0] op, input bit m3);
    xfer(op, qpi ? 2 : 8, 0, m3);
  endtask

  task automatic rdsr(input logic [7:0] e, input string t, input bit m3, input int nbytes);
    for (int b = 0; b < nbytes; b++) begin
      exp_q.push_back(e);
      tag_q.push_back(t);
    end
    xfer(8'h05, qpi ? 2 : 8, nbytes * (qpi ? 2 : 8), m3);
  endtask

  task automatic erase(input logic [7:0] op, input bit m3);
    cmd(op, m3);
    erase_cs = cs_cyc;
    lat_expect = 1;
  endtask

  task automatic wait_erase();
    while (cyc < erase_cs + TCE + 20) tick(1);
  endtask

  initial begin
    rst_n = 1'b0; csn = 1'b1; sck = 1'b0; io_in = 4'h0;
    qpi = 1'b0; cmp = 1'b0; bp = 3'b000; lock = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk(io_oe === 4'h0, "R13 reset io_oe", {28'h0, io_oe}, 32'h0);
    chk(clr === 1'b0, "R13 reset array_clear", {31'h0, clr}, 32'h0);
    rdsr(8'h00, "R13 reset status", 0, 1);

    // R2: erase without write enable
    cmd(8'hC7, 0);
    rdsr(8'h00, "R2 refused without enable", 0, 1);

    // R8: write enable
    cmd(8'h06, 0);
    rdsr(8'h02, "R8 enable set", 0, 1);

    // R3: short and long frames
    xfer(8'hC7, 7, 0, 0);
    rdsr(8'h02, "R3 seven-bit frame discarded", 0, 1);
    xfer(8'hC7, 9, 0, 0);
    rdsr(8'h02, "R3 nine-bit frame discarded", 0, 1);

    // R4: protection
    bp = 3'b001;
    cmd(8'hC7, 0);
    rdsr(8'h02, "R4 block field set", 0, 1);
    bp = 3'b000; cmp = 1'b1;
    cmd(8'hC7, 0);
    rdsr(8'h02, "R4 complement with empty field", 0, 1);
    cmp = 1'b0; lock = 1'b1;
    cmd(8'h60, 0);
    rdsr(8'h02, "R4 individual lock", 0, 1);
    lock = 1'b0;
    chk(clr_cnt == 0, "R4 no strobe while refused", clr_cnt, 0);

    // R1/R5/R7/R9/R6: complement with full field leaves nothing locked
    cmp = 1'b1; bp = 3'b111;
    erase(8'hC7, 0);
    rdsr(8'h03, "R5 busy during erase", 0, 1);
    cmd(8'hC7, 0);
    cmd(8'h06, 0);
    rdsr(8'h03, "R7 repeated status while busy", 0, 2);
    wait_erase();
    chk(clr_cnt == 1, "R1 erase C7 strobes once", clr_cnt, 1);
    rdsr(8'h00, "R6 flags cleared; R9 second erase ignored", 0, 1);
    cmp = 1'b0; bp = 3'b000;

    // R10: mode 3 with opcode 60h
    cmd(8'h06, 1);
    rdsr(8'h02, "R10 mode 3 enable", 1, 1);
    erase(8'h60, 1);
    rdsr(8'h03, "R10 mode 3 busy", 1, 1);
    wait_erase();
    chk(clr_cnt == 2, "R1 erase 60h strobes once", clr_cnt, 2);
    rdsr(8'h00, "R10 mode 3 done", 1, 1);

    // R11: four-lane mode
    qpi = 1'b1;
    xfer(8'h06, 1, 0, 0);
    rdsr(8'h00, "R3 one-clock quad frame discarded", 0, 1);
    xfer(8'h06, 3, 0, 0);
    rdsr(8'h00, "R3 three-clock quad frame discarded", 0, 1);
    cmd(8'h06, 0);
    rdsr(8'h02, "R11 quad enable", 0, 1);
    erase(8'h60, 1);
    rdsr(8'h03, "R11 quad busy", 1, 2);
    wait_erase();
    chk(clr_cnt == 3, "R11 quad erase strobes once", clr_cnt, 3);
    rdsr(8'h00, "R11 quad done", 1, 1);

    tick(20);
    chk(exp_q.size() == 0, "R7 all status bytes returned", exp_q.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule